// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM controller

This block sits between a simple synchronous host port and an external 16-bit asynchronous static RAM. It turns each accepted host request into a sequence of active-low strobes: chip select, write strobe, output enable and two byte-lane selects. It also drives the data pads in the correct direction. The data pad is split into an output value, an output-enable and an input value, so the tri-state buffer itself can live in the pad ring.

Every access runs in fixed phases. Their lengths are set in clock cycles by parameters. Before any strobe falls, the address is presented for a setup period. A write then holds all of its strobes low together for the pulse period. After the pulse, all strobes rise together and the write data stays driven for a hold period. A read holds chip select, output enable and the selected lane strobes low for the access period. It captures the selected lanes at the end of that period and then reports them with a one-cycle valid pulse. Between accesses every strobe is high, so the memory stays in standby.

A byte mask picks the lanes: bit 0 is the low byte (data bits 7:0) and bit 1 is the high byte (data bits 15:8). A request with an empty mask touches no pin and completes at once.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset, and whenever the controller is idle, `ready_o` is 1, `rvalid_o` is 0 and `dq_oe_o` is 0. A request is taken only on a rising edge where both `req_i` and `ready_o` are 1. A request raised while `ready_o` is 0 is ignored.
- R2: While `ready_o` is 1, all five memory strobes (`sram_ce_no`, `sram_we_no`, `sram_oe_no`, `sram_ub_no`, `sram_lb_no`) are 1, so the memory is in standby.
- R3: A write with a non-empty mask keeps `ready_o` at 0 for exactly T_SETUP+T_PULSE+T_HOLD cycles, in three phases:
  - For T_SETUP cycles, all strobes stay high.
  - For T_PULSE cycles, `sram_ce_no` and `sram_we_no` are 0.
  - For T_HOLD cycles, all strobes are high again.
- R4: `sram_oe_no` stays 1 whenever `sram_we_no` is 0 or `dq_oe_o` is 1. The controller and the memory never drive the data pads at the same time.
- R5: `dq_oe_o` is 1 only during the pulse and hold phases of a write, for exactly T_PULSE+T_HOLD cycles. While it is 1, `dq_o` carries the accepted write data.
- R6: A read with a non-empty mask keeps `ready_o` at 0 for exactly T_SETUP+T_ACCESS cycles. All strobes stay high for the first T_SETUP cycles. For the next T_ACCESS cycles, `sram_ce_no` and `sram_oe_no` are 0 and `sram_we_no` is 1.
- R7: In the first cycle that `ready_o` is 1 again after a read, `rvalid_o` is 1 for that one cycle. Each lane of `rdata_o` holds the memory data for that lane if the lane's mask bit is 1, and holds 0 otherwise.
- R8: While `sram_ce_no` is 0, `sram_addr_o` does not change. Consecutive accesses are always separated by `sram_ce_no` being 1.
- R9: While chip select is low, a lane strobe (`sram_lb_no` for mask bit 0, `sram_ub_no` for mask bit 1) is 0 exactly when its mask bit is 1.
- R10: A request with mask 0 makes no strobe fall and leaves `ready_o` at 1. For a write, memory is unchanged. For a read, `rvalid_o` is 1 in the next cycle with `rdata_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | 16 | Write data |
| bmask_i | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| ready_o | output | 1 | Idle, request can be taken |
| rdata_o | output | 16 | Read data, unselected lanes are 0 |
| rvalid_o | output | 1 | One-cycle read-data valid |
| sram_addr_o | output | AW | Memory address |
| sram_ce_no | output | 1 | Chip select, active low |
| sram_we_no | output | 1 | Write strobe, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_ub_no | output | 1 | High-byte select, active low |
| sram_lb_no | output | 1 | Low-byte select, active low |
| dq_o | output | 16 | Data to pads |
| dq_oe_o | output | 1 | Pad drive enable |
| dq_i | input | 16 | Data from pads |

## Verification
Two of the block's functions can fall in the same cycle.

- **Read result and new request.** The read-valid pulse lands in the same cycle that `ready_o` returns, so the next request can be presented in that very cycle. The bench issues back-to-back random operations with no gap. It checks that the returned lanes match its shadow memory and that the strobes of the new access still begin with a full setup phase.
- **Write end and next address.** The write hold phase and the next access's address change can meet at the boundary between two operations. A behavioural memory model in the bench commits each write only when the pulse ends. At that point it checks that the pads are still driven with the same data and that the address did not move while chip select was low.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD,
    PH_RSETUP,
    PH_RACCESS
  } phase_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int LANES    = DW / 8,
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 2,
  parameter int T_HOLD   = 1,
  parameter int T_ACCESS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] bmask_i,
  output phase_e           phase_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    wdata_o,
  output logic [LANES-1:0] mask_o,
  output logic             rd_done_o,
  output logic             rd_nop_o
);

  localparam int TMAX = max4(T_SETUP, T_PULSE, T_HOLD, T_ACCESS);
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          accept;
  logic          last;

  assign accept    = req_i && (phase_q == PH_IDLE);
  assign last      = (cnt_q == '0);
  assign rd_done_o = (phase_q == PH_RACCESS) && last;
  // empty-mask read is answered from the capture stage without touching the pins
  assign rd_nop_o  = accept && !we_i && (bmask_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
      mask_o  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (accept && (bmask_i != '0)) begin
            addr_o  <= addr_i;
            wdata_o <= wdata_i;
            mask_o  <= bmask_i;
            cnt_q   <= CW'(T_SETUP - 1);
            phase_q <= we_i ? PH_WSETUP : PH_RSETUP;
          end
        end
        PH_WSETUP: begin
          if (last) begin
            cnt_q   <= CW'(T_PULSE - 1);
            phase_q <= PH_WPULSE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_WPULSE: begin
          if (last) begin
            cnt_q   <= CW'(T_HOLD - 1);
            phase_q <= PH_WHOLD;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_WHOLD: begin
          if (last) phase_q <= PH_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        PH_RSETUP: begin
          if (last) begin
            cnt_q   <= CW'(T_ACCESS - 1);
            phase_q <= PH_RACCESS;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_RACCESS: begin
          if (last) phase_q <= PH_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe
  import sram_lane_pkg::*;
#(
  parameter int LANES = 2
) (
  input  phase_e           phase_i,
  input  logic [LANES-1:0] mask_i,
  output logic             ce_no,
  output logic             we_no,
  output logic             oe_no,
  output logic [LANES-1:0] lane_no,
  output logic             dq_oe_o
);

  logic wr_act, rd_act, any_act;

  assign wr_act  = (phase_i == PH_WPULSE);
  assign rd_act  = (phase_i == PH_RACCESS);
  assign any_act = wr_act || rd_act;

  // all strobes fall and rise on the same clock edge
  assign ce_no   = !any_act;
  assign we_no   = !wr_act;
  assign oe_no   = !rd_act;
  assign dq_oe_o = wr_act || (phase_i == PH_WHOLD);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_no[i] = !(any_act && mask_i[i]);
  end

endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap #(
  parameter int DW    = 16,
  parameter int LANES = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             nop_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_o <= 1'b0;
    else         rvalid_o <= done_i || nop_i;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_o[i*8 +: 8] <= '0;
      else if (done_i) rdata_o[i*8 +: 8] <= mask_i[i] ? dq_i[i*8 +: 8] : 8'h00;
      else if (nop_i) rdata_o[i*8 +: 8] <= 8'h00;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW       = 18,
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 2,
  parameter int T_HOLD   = 1,
  parameter int T_ACCESS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  input  logic [1:0]    bmask_i,
  output logic          ready_o,
  output logic [15:0]   rdata_o,
  output logic          rvalid_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce_no,
  output logic          sram_we_no,
  output logic          sram_oe_no,
  output logic          sram_ub_no,
  output logic          sram_lb_no,
  output logic [15:0]   dq_o,
  output logic          dq_oe_o,
  input  logic [15:0]   dq_i
);

  localparam int DW    = 16;
  localparam int LANES = DW / 8;

  phase_e           phase;
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] lane_n;
  logic             rd_done, rd_nop;

  sram_lane_seq #(
    .AW(AW), .DW(DW), .LANES(LANES),
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_ACCESS(T_ACCESS)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .bmask_i   (bmask_i),
    .phase_o   (phase),
    .addr_o    (sram_addr_o),
    .wdata_o   (dq_o),
    .mask_o    (mask_q),
    .rd_done_o (rd_done),
    .rd_nop_o  (rd_nop)
  );

  sram_lane_strobe #(.LANES(LANES)) u_strobe (
    .phase_i (phase),
    .mask_i  (mask_q),
    .ce_no   (sram_ce_no),
    .we_no   (sram_we_no),
    .oe_no   (sram_oe_no),
    .lane_no (lane_n),
    .dq_oe_o (dq_oe_o)
  );

  sram_lane_rdcap #(.DW(DW), .LANES(LANES)) u_rdcap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (rd_done),
    .nop_i    (rd_nop),
    .mask_i   (mask_q),
    .dq_i     (dq_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign sram_lb_no = lane_n[0];
  assign sram_ub_no = lane_n[1];
  assign ready_o    = (phase == PH_IDLE);

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int AW      = 18,
  parameter int T_PULSE = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic          sram_ce_no,
  input logic          sram_we_no,
  input logic          sram_oe_no,
  input logic          sram_ub_no,
  input logic          sram_lb_no,
  input logic          dq_oe_o,
  input logic [AW-1:0] sram_addr_o
);

  logic [15:0] wlo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wlo_q <= '0;
    else if (sram_we_no) wlo_q <= '0;
    else                 wlo_q <= wlo_q + 1'b1;
  end

  p_standby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no && sram_ub_no && sram_lb_no));

  p_idle_no_drive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !dq_oe_o);

  p_we_needs_ce_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && (!sram_ub_no || !sram_lb_no)));

  p_pulse_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (wlo_q == 16'(T_PULSE)));

  p_no_contention_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no || dq_oe_o) |-> sram_oe_no);

  p_hold_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (dq_oe_o && sram_ce_no && sram_ub_no && sram_lb_no));

  p_rvalid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ready_o);

  p_addr_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce_no |=> (sram_ce_no || $stable(sram_addr_o)));

endmodule

bind sram_lane_ctrl sram_lane_chk #(.AW(AW), .T_PULSE(T_PULSE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .sram_ce_no  (sram_ce_no),
  .sram_we_no  (sram_we_no),
  .sram_oe_no  (sram_oe_no),
  .sram_ub_no  (sram_ub_no),
  .sram_lb_no  (sram_lb_no),
  .dq_oe_o     (dq_oe_o),
  .sram_addr_o (sram_addr_o)
);

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;

  localparam int AW = 8;
  localparam int TS = 2;
  localparam int TP = 3;
  localparam int TH = 1;
  localparam int TA = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [1:0]    bmask = '0;
  logic          ready, rvalid, ce_n, we_n, oe_n, ub_n, lb_n, dq_oe;
  logic [15:0]   rdata, dq_o, dq_i;
  logic [AW-1:0] saddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_lane_ctrl #(.AW(AW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_ACCESS(TA)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .bmask_i(bmask), .ready_o(ready), .rdata_o(rdata),
    .rvalid_o(rvalid), .sram_addr_o(saddr), .sram_ce_no(ce_n), .sram_we_no(we_n),
    .sram_oe_no(oe_n), .sram_ub_no(ub_n), .sram_lb_no(lb_n), .dq_o(dq_o),
    .dq_oe_o(dq_oe), .dq_i(dq_i)
  );

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int i);
    return {i[7:0], ~i[7:0]};
  endfunction

  function automatic logic [15:0] lane_merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] lane_pick(input logic [15:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  // behavioural memory
  logic [15:0]   mem [256];
  logic [15:0]   exp_mem [256];
  logic          wr_act = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  logic [1:0]    wr_lanes;

  always_comb begin
    dq_i[7:0]  = (!ce_n && !oe_n && we_n && !lb_n) ? mem[saddr][7:0]  : 8'h5A;
    dq_i[15:8] = (!ce_n && !oe_n && we_n && !ub_n) ? mem[saddr][15:8] : 8'hC3;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ce_n && !we_n) begin
        if (wr_act) chk(saddr == wr_addr, "R8 address moved during pulse", 32'(saddr), 32'(wr_addr));
        wr_act   <= 1'b1;
        wr_addr  <= saddr;
        wr_data  <= dq_o;
        wr_lanes <= {~ub_n, ~lb_n};
      end else if (wr_act) begin
        chk(dq_oe && dq_o == wr_data, "R5 hold data", {15'd0, dq_oe, dq_o}, {16'd1, wr_data});
        mem[wr_addr] <= lane_merge(mem[wr_addr], wr_data, wr_lanes);
        wr_act <= 1'b0;
      end
    end
  end

  task automatic op(input logic wr, input logic [AW-1:0] a, input logic [15:0] d,
                    input logic [1:0] m, input bit poke);
    int busy, nwe, noe, ndrv, lbad;
    int exp_busy;
    logic [15:0] exp_rd;
    while (!ready) @(negedge clk);
    req = 1'b1; we = wr; addr = a; wdata = d; bmask = m;
    @(negedge clk);
    req = 1'b0;
    busy = 0; nwe = 0; noe = 0; ndrv = 0; lbad = 0;
    while (!ready && busy < 1000) begin
      busy++;
      if (!we_n) nwe++;
      if (!oe_n) noe++;
      if (dq_oe) ndrv++;
      if (!ce_n && {ub_n, lb_n} != ~m) lbad++;
      if (poke && busy == 1) begin
        req = 1'b1; we = 1'b1; addr = a ^ 8'h55; wdata = 16'hDEAD; bmask = 2'b11;
      end else req = 1'b0;
      @(negedge clk);
    end
    req = 1'b0;
    exp_busy = (m == 2'b00) ? 0 : (wr ? TS + TP + TH : TS + TA);
    chk(busy == exp_busy, wr ? "R3 write busy length" : "R6 read busy length", busy, exp_busy);
    chk(nwe == ((wr && m != 0) ? TP : 0), "R3 write strobe cycles", nwe, (wr && m != 0) ? TP : 0);
    chk(noe == ((!wr && m != 0) ? TA : 0), "R6 output enable cycles", noe, (!wr && m != 0) ? TA : 0);
    chk(ndrv == ((wr && m != 0) ? TP + TH : 0), "R5 drive cycles", ndrv, (wr && m != 0) ? TP + TH : 0);
    chk(lbad == 0, "R9 lane strobes", lbad, 0);
    chk(ce_n && we_n && oe_n && ub_n && lb_n, "R2 standby after op",
        {ce_n, we_n, oe_n, ub_n, lb_n}, 5'h1F);
    if (wr) begin
      exp_mem[a] = lane_merge(exp_mem[a], d, m);
      chk(!rvalid, "R1 no rvalid after write", rvalid, 0);
    end else begin
      exp_rd = lane_pick(exp_mem[a], m);
      chk(rvalid && rdata == exp_rd, m == 0 ? "R10 empty read" : "R7 read data",
          {15'd0, rvalid, rdata}, {16'd1, exp_rd});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_word(i);
      exp_mem[i] = init_word(i);
    end
    void'($urandom(32'h5eed_1234));
    #5;
    chk(ready && !rvalid && !dq_oe, "R1 reset outputs", {ready, rvalid, dq_oe}, 3'b100);
    chk(ce_n && we_n && oe_n && ub_n && lb_n, "R2 reset standby", {ce_n, we_n, oe_n, ub_n, lb_n}, 5'h1F);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !rvalid && !dq_oe, "R1 idle after reset", {ready, rvalid, dq_oe}, 3'b100);

    // directed corners
    op(1'b1, 8'h10, 16'h1234, 2'b11, 1'b0);
    op(1'b0, 8'h10, 16'h0000, 2'b11, 1'b0);
    @(negedge clk);
    chk(!rvalid, "R7 rvalid single cycle", rvalid, 0);
    op(1'b1, 8'h10, 16'hABCD, 2'b01, 1'b0);
    op(1'b0, 8'h10, 16'h0000, 2'b11, 1'b0);
    op(1'b1, 8'h10, 16'h7700, 2'b10, 1'b0);
    op(1'b0, 8'h10, 16'h0000, 2'b01, 1'b0);
    op(1'b0, 8'h10, 16'h0000, 2'b10, 1'b0);
    op(1'b1, 8'h20, 16'hFFFF, 2'b00, 1'b0);  // R10 empty write
    op(1'b0, 8'h20, 16'h0000, 2'b11, 1'b0);
    op(1'b0, 8'h20, 16'h0000, 2'b00, 1'b0);  // R10 empty read
    op(1'b1, 8'h30, 16'h4242, 2'b11, 1'b1);  // R1 request while busy
    op(1'b0, 8'h30 ^ 8'h55, 16'h0000, 2'b11, 1'b0);
    op(1'b1, 8'h40, 16'h0101, 2'b11, 1'b0);  // R8 back-to-back writes
    op(1'b1, 8'h41, 16'h0202, 2'b11, 1'b0);
    op(1'b0, 8'h40, 16'h0000, 2'b11, 1'b0);
    op(1'b0, 8'h41, 16'h0000, 2'b11, 1'b0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) != 0 && m == 2'b00) m = 2'b11;
      op(1'($urandom_range(0, 1)), AW'($urandom_range(0, 15)), 16'($urandom), m, 1'b0);
    end
    for (int i = 0; i < 16; i++) op(1'b0, AW'(i), 16'h0000, 2'b11, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule